// File: doc/BRIEF.md
# Current-Detect Threshold Monitor

This block watches the signed conversion results of a small group of current channels while the main supply is absent and decides whether tamper current is flowing. An accepted start opens a measurement window that lasts a programmable number of conversion periods. During the window, each enabled channel counts the samples whose magnitude lies strictly above a programmable threshold. When the counts satisfy the selected combining rule, a latched detect flag is raised. The rule is either "any enabled channel has reached the required count" or "every enabled channel has reached it".

The window closes either on its last sample or as soon as detection fires, whichever comes first. At that point the block drops back to standby and emits a one-cycle done pulse. The threshold, required count, window length, channel mask and combining mode are captured at the accepted start and held for the whole window, so a controller can change them freely between windows.

Top module: `cur_detect_mon`

## Requirements
- R1: After reset, `busy`, `done` and `detect` are all 0.
- R2: A `start` high in a cycle with `busy` low and `det_en` high opens a window: `busy` is 1 from the next cycle and `detect` is cleared. A `start` with `det_en` low leaves `busy` at 0 and leaves `detect` unchanged.
- R3: A sample counts as an exceedance only when its absolute value is strictly greater than `cfg_thr`, which is treated as unsigned. A sample equal to the threshold does not count. Samples are 24-bit two's complement, and the code 0x800000 counts as magnitude 2^23.
- R4: Channel i takes part only when bit i of `cfg_mask` was 1 at the accepted start. Samples on a masked channel never contribute to detection.
- R5: With `cfg_all`=0, detection fires on the valid sample at which any enabled channel's exceedance count reaches `cfg_need`. A `cfg_need` of 0 fires on the first sample.
- R6: With `cfg_all`=1, detection fires only on the valid sample at which every enabled channel has reached `cfg_need`. An empty mask never fires.
- R7: The window holds `cfg_len` valid samples, with 0 acting as 1. The cycle after the last one, `busy` is 0 and `done` is 1 for exactly one cycle. `detect` stays 0 if the rule was not met.
- R8: When detection fires before the last sample, `detect` and `done` are 1 and `busy` is 0 in the cycle after the firing sample. No further samples are counted.
- R9: `detect` keeps its value while idle, until the next accepted start.
- R10: `start` while `busy` is 1 has no effect. Samples are counted only when `smp_valid` is 1 and `busy` is 1.
- R11: When detection fires on the last sample of the window, exactly one `done` pulse is produced and `detect` is 1.
- R12: Changes to `cfg_thr`, `cfg_need`, `cfg_len`, `cfg_mask` and `cfg_all` while `busy` is 1 have no effect on the current window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| det_en | input | 1 | Detector enable; gates start |
| start | input | 1 | Start request strobe |
| cfg_all | input | 1 | 0 = any enabled channel, 1 = all enabled channels |
| cfg_mask | input | NUM_CH | Channel enable mask |
| cfg_thr | input | SMP_W | Magnitude threshold (unsigned) |
| cfg_need | input | HIT_W | Required exceedance count |
| cfg_len | input | WIN_W | Window length in conversion periods |
| smp_valid | input | 1 | Conversion result strobe |
| smp_data | input | NUM_CH*SMP_W | Packed signed samples, channel i at bits [i*SMP_W +: SMP_W] |
| detect | output | 1 | Latched detection flag |
| done | output | 1 | One-cycle window-closed pulse |
| busy | output | 1 | Window active |

## Verification
Two things can happen on the same sample: the window can expire, and the counts can satisfy the combining rule. Both close the window. The bench provokes the overlap by setting the window length equal to the required count and making every sample exceed on all channels. Detection and expiry then land on one edge, and the bench expects a single `done` pulse with `detect` set and no second pulse after it. A behavioural reference model, kept with plain integers, predicts `busy`, `done` and `detect` for every clock. It is run against the same overlap in any-channel and all-channel modes.

// File: rtl/cdm_pkg.sv
package cdm_pkg;
   typedef enum logic {
      CMB_ANY = 1'b0,
      CMB_ALL = 1'b1
   } cdm_combine_e;

   typedef enum logic {
      WST_IDLE = 1'b0,
      WST_RUN  = 1'b1
   } cdm_wstate_e;
endpackage

// File: rtl/cdm_mag_cmp.sv
module cdm_mag_cmp #(
   parameter int SMP_W = 24
) (
   input  logic [SMP_W-1:0] smp,
   input  logic [SMP_W-1:0] thr,
   output logic             over
);
   logic [SMP_W-1:0] mag;

   // two's complement negate; the most negative code maps to 2^(SMP_W-1) unsigned
   always_comb begin
      if (smp[SMP_W-1]) mag = ~smp + 1'b1;
      else              mag = smp;
      over = (mag > thr);
   end
endmodule

// File: rtl/cdm_hit_ctr.sv
module cdm_hit_ctr #(
   parameter int HIT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic [HIT_W-1:0] need,
   output logic             reached
);
   localparam logic [HIT_W-1:0] CNT_MAX = {HIT_W{1'b1}};

   logic [HIT_W-1:0] cnt_q;
   logic [HIT_W-1:0] cnt_nx;

   always_comb begin
      cnt_nx = cnt_q;
      if (inc && (cnt_q != CNT_MAX)) cnt_nx = cnt_q + 1'b1;
      reached = (cnt_nx >= need);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else          cnt_q <= cnt_nx;
   end
endmodule

// File: rtl/cdm_window_ctl.sv
module cdm_window_ctl
   import cdm_pkg::*;
#(
   parameter int WIN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             tick,
   input  logic             fire,
   input  logic [WIN_W-1:0] len,
   output logic             busy,
   output logic             done
);
   cdm_wstate_e      st_q;
   logic [WIN_W-1:0] win_q;
   logic [WIN_W:0]   win_inc;
   logic             last;

   always_comb begin
      win_inc = {1'b0, win_q} + 1'b1;
      last    = (win_inc >= {1'b0, len});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= WST_IDLE;
         win_q <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st_q)
            WST_IDLE: begin
               if (go) begin
                  st_q  <= WST_RUN;
                  win_q <= '0;
               end
            end
            WST_RUN: begin
               if (tick) begin
                  win_q <= win_inc[WIN_W-1:0];
                  if (last || fire) begin
                     st_q <= WST_IDLE;
                     done <= 1'b1;
                  end
               end
            end
            default: st_q <= WST_IDLE;
         endcase
      end
   end

   assign busy = (st_q == WST_RUN);
endmodule

// File: rtl/cur_detect_mon.sv
module cur_detect_mon
   import cdm_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int SMP_W  = 24,
   parameter int HIT_W  = 8,
   parameter int WIN_W  = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    det_en,
   input  logic                    start,
   input  logic                    cfg_all,
   input  logic [NUM_CH-1:0]       cfg_mask,
   input  logic [SMP_W-1:0]        cfg_thr,
   input  logic [HIT_W-1:0]        cfg_need,
   input  logic [WIN_W-1:0]        cfg_len,
   input  logic                    smp_valid,
   input  logic [NUM_CH*SMP_W-1:0] smp_data,
   output logic                    detect,
   output logic                    done,
   output logic                    busy
);
   localparam int DATA_W = NUM_CH * SMP_W;

   if (NUM_CH < 1) begin : g_bad_ch
      $error("cur_detect_mon: NUM_CH must be at least 1");
   end
   if (SMP_W < 2) begin : g_bad_smp
      $error("cur_detect_mon: SMP_W must be at least 2");
   end
   if (HIT_W < 1 || WIN_W < 1) begin : g_bad_cnt
      $error("cur_detect_mon: counter widths must be positive");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("cur_detect_mon: data bus too narrow");
   end

   // configuration captured at the accepted start
   cdm_combine_e        cmb_q;
   logic [NUM_CH-1:0]   mask_q;
   logic [SMP_W-1:0]    thr_q;
   logic [HIT_W-1:0]    need_q;
   logic [WIN_W-1:0]    len_q;

   logic                go;
   logic                tick;
   logic                fire;
   logic [NUM_CH-1:0]   over;
   logic [NUM_CH-1:0]   reached;
   logic                any_hit;
   logic                all_hit;

   assign go   = start && det_en && !busy;
   assign tick = busy && smp_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmb_q  <= CMB_ANY;
         mask_q <= '0;
         thr_q  <= '0;
         need_q <= '0;
         len_q  <= '0;
      end else if (go) begin
         cmb_q  <= cdm_combine_e'(cfg_all);
         mask_q <= cfg_mask;
         thr_q  <= cfg_thr;
         need_q <= cfg_need;
         len_q  <= cfg_len;
      end
   end

   for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
      cdm_mag_cmp #(.SMP_W(SMP_W)) i_cmp (
         .smp  (smp_data[gi*SMP_W +: SMP_W]),
         .thr  (thr_q),
         .over (over[gi])
      );

      cdm_hit_ctr #(.HIT_W(HIT_W)) i_ctr (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (go),
         .inc     (tick && mask_q[gi] && over[gi]),
         .need    (need_q),
         .reached (reached[gi])
      );
   end

   if (NUM_CH == 1) begin : g_single
      assign any_hit = mask_q[0] && reached[0];
      assign all_hit = any_hit;
   end else begin : g_multi
      assign any_hit = |(reached & mask_q);
      assign all_hit = (|mask_q) && (&(reached | ~mask_q));
   end

   assign fire = (cmb_q == CMB_ALL) ? all_hit : any_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            detect <= 1'b0;
      else if (go)           detect <= 1'b0;
      else if (tick && fire) detect <= 1'b1;
   end

   cdm_window_ctl #(.WIN_W(WIN_W)) i_win (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (go),
      .tick  (tick),
      .fire  (fire),
      .len   (len_q),
      .busy  (busy),
      .done  (done)
   );
endmodule

// File: rtl/cdm_checker.sv
module cdm_checker (
   input logic clk,
   input logic rst_n,
   input logic det_en,
   input logic start,
   input logic smp_valid,
   input logic busy,
   input logic done,
   input logic detect
);
   AST_START_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && !det_en) |=> !busy); // R2

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7

   AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done); // R8

   AST_DETECT_RISE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(detect) |-> (done && !busy)); // R8

   AST_DETECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !(start && det_en)) |=> $stable(detect)); // R9

   AST_RUN_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !smp_valid) |=> (busy && !done)); // R10
endmodule

bind cur_detect_mon cdm_checker i_cdm_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .det_en    (det_en),
   .start     (start),
   .smp_valid (smp_valid),
   .busy      (busy),
   .done      (done),
   .detect    (detect)
);

// File: tb/test_cur_detect_mon.sv
module test_cur_detect_mon;
   localparam int NCH = 3;
   localparam int SW  = 24;
   localparam int HW  = 8;
   localparam int WW  = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            det_en = 1'b0;
   logic            start = 1'b0;
   logic            cfg_all = 1'b0;
   logic [NCH-1:0]  cfg_mask = 3'b111;
   logic [SW-1:0]   cfg_thr = 24'd80000;
   logic [HW-1:0]   cfg_need = 8'd8;
   logic [WW-1:0]   cfg_len = 16'd256;
   logic            smp_valid = 1'b0;
   logic [NCH*SW-1:0] smp_data = '0;
   logic            detect, done, busy;

   always #4 clk = ~clk; // 125 MHz

   cur_detect_mon #(.NUM_CH(NCH), .SMP_W(SW), .HIT_W(HW), .WIN_W(WW)) i_cur_detect_mon (
      .clk(clk), .rst_n(rst_n), .det_en(det_en), .start(start), .cfg_all(cfg_all),
      .cfg_mask(cfg_mask), .cfg_thr(cfg_thr), .cfg_need(cfg_need), .cfg_len(cfg_len),
      .smp_valid(smp_valid), .smp_data(smp_data),
      .detect(detect), .done(done), .busy(busy));

   int    n_chk = 0;
   int    n_fail = 0;
   string cur_req = "R1";

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // behavioural reference model
   int m_busy = 0, m_done = 0, m_det = 0, m_win = 0;
   int m_cnt[NCH];
   int l_all, l_mask, l_thr, l_need, l_len;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_det = 0; m_win = 0;
      end else begin
         m_done = 0;
         if (m_busy == 0) begin
            if (start && det_en) begin
               m_busy = 1; m_det = 0; m_win = 0;
               foreach (m_cnt[k]) m_cnt[k] = 0;
               l_all = cfg_all; l_mask = int'(cfg_mask); l_thr = int'(cfg_thr);
               l_need = int'(cfg_need); l_len = int'(cfg_len);
            end
         end else if (smp_valid) begin
            int any_r, all_r, n_en, fire;
            any_r = 0; all_r = 1; n_en = 0;
            for (int k = 0; k < NCH; k++) begin
               logic signed [SW-1:0] v;
               int iv, a;
               v  = smp_data[k*SW +: SW];
               iv = v;
               a  = (iv < 0) ? -iv : iv;
               if (l_mask[k]) begin
                  n_en++;
                  if (a > l_thr) m_cnt[k]++;
                  if (m_cnt[k] >= l_need) any_r = 1; else all_r = 0;
               end
            end
            fire = l_all ? (all_r && n_en > 0) : any_r;
            m_win++;
            if (fire) m_det = 1;
            if (fire || m_win >= l_len) begin
               m_busy = 0; m_done = 1;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         check(busy === (m_busy != 0), cur_req, "busy", int'(busy), m_busy);
         check(done === (m_done != 0), cur_req, "done", int'(done), m_done);
         check(detect === (m_det != 0), cur_req, "detect", int'(detect), m_det);
      end
   end

   // stimulus helpers: entered and left just after a falling edge
   task automatic tick_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic go();
      start = 1'b1; @(negedge clk); start = 1'b0;
   endtask

   task automatic smp(input int a, input int b, input int c);
      smp_data = {SW'(c), SW'(b), SW'(a)};
      smp_valid = 1'b1;
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic defaults();
      cfg_all = 1'b0; cfg_mask = 3'b111; cfg_thr = 24'd80000;
      cfg_need = 8'd8; cfg_len = 16'd256;
   endtask

   task automatic run_out();
      for (int i = 0; i < 300 && busy; i++) smp(0, 0, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      cur_req = "R1";
      check(busy === 1'b0 && done === 1'b0 && detect === 1'b0, "R1", "reset outputs",
            int'({busy, done, detect}), 0);
      rst_n = 1'b1;
      tick_n(2);

      // R2: start ignored while disabled
      cur_req = "R2";
      det_en = 1'b0; go(); tick_n(1);
      check(busy === 1'b0, "R2", "busy after disabled start", int'(busy), 0);
      det_en = 1'b1;

      // R3/R5: any mode, equality not counted, negative counted, fires on 8th
      cur_req = "R3";
      defaults(); go();
      check(busy === 1'b1, "R2", "busy after start", int'(busy), 1);
      smp(0, 80000, 0); smp(0, -80000, 0);
      for (int i = 0; i < 7; i++) smp(0, (i % 2) ? 80001 : -80001, 5);
      check(detect === 1'b0 && busy === 1'b1, "R3", "detect after 7 hits",
            int'(detect), 0);
      cur_req = "R5";
      smp(0, 90000, 0);
      check(detect === 1'b1, "R5", "detect on 8th hit", int'(detect), 1);
      check(done === 1'b1 && busy === 1'b0, "R8", "early close", int'({done, busy}), 2);
      smp(0, 90000, 0);
      check(done === 1'b0, "R8", "done single pulse", int'(done), 0);

      // R9: detect latched while idle and across a blocked start
      cur_req = "R9";
      tick_n(3); det_en = 1'b0; go(); tick_n(1);
      check(detect === 1'b1, "R9", "detect held", int'(detect), 1);
      det_en = 1'b1; go();
      check(detect === 1'b0, "R9", "detect cleared by start", int'(detect), 0);
      run_out();

      // R7: window expiry without detection
      cur_req = "R7";
      cfg_len = 16'd16; go();
      for (int i = 0; i < 15; i++) smp(100, -200, 300);
      check(busy === 1'b1, "R7", "busy before last", int'(busy), 1);
      smp(100, -200, 300);
      check(busy === 1'b0 && done === 1'b1 && detect === 1'b0, "R7", "window end",
            int'({busy, done, detect}), 2);

      // R7: length 0 acts as 1
      cfg_len = 16'd0; go(); smp(0, 0, 0);
      check(done === 1'b1, "R7", "zero length closes on first sample", int'(done), 1);

      // R4: masked channel ignored
      cur_req = "R4";
      defaults(); cfg_mask = 3'b101; cfg_len = 16'd12; cfg_need = 8'd2; go();
      for (int i = 0; i < 12; i++) smp(0, 500000, 0);
      check(detect === 1'b0, "R4", "masked channel no detect", int'(detect), 0);

      // R10: start while busy and gaps in valid
      cur_req = "R10";
      defaults(); cfg_need = 8'd3; go();
      smp(100000, 0, 0); tick_n(4); go(); tick_n(2);
      smp(100000, 0, 0);
      check(detect === 1'b0 && busy === 1'b1, "R10", "restart ignored", int'(detect), 0);
      smp(100000, 0, 0);
      check(detect === 1'b1, "R10", "count kept across start", int'(detect), 1);

      // R6: all mode
      cur_req = "R6";
      defaults(); cfg_all = 1'b1; cfg_need = 8'd3; cfg_len = 16'd10; go();
      for (int i = 0; i < 3; i++) smp(100000, 0, -100000);
      check(detect === 1'b0, "R6", "one channel short", int'(detect), 0);
      smp(0, 100000, 0); smp(0, 100000, 0);
      check(detect === 1'b0, "R6", "still short", int'(detect), 0);
      smp(0, 100000, 0);
      check(detect === 1'b1, "R6", "all reached", int'(detect), 1);
      cfg_mask = 3'b000; go();
      for (int i = 0; i < 10; i++) smp(900000, 900000, 900000);
      check(detect === 1'b0 && done === 1'b1, "R6", "empty mask", int'(detect), 0);

      // R3: most negative code
      cur_req = "R3";
      defaults(); cfg_thr = 24'h7FFFFF; cfg_need = 8'd2; go();
      smp(-8388608, 0, 0); smp(-8388608, 0, 0);
      check(detect === 1'b1, "R3", "min code exceeds max threshold", int'(detect), 1);

      // R11: detection on the last sample, both modes
      cur_req = "R11";
      for (int md = 0; md < 2; md++) begin
         defaults(); cfg_all = md[0]; cfg_need = 8'd5; cfg_len = 16'd5; go();
         for (int i = 0; i < 5; i++) smp(-200000, 200000, 300000);
         check(detect === 1'b1 && done === 1'b1 && busy === 1'b0, "R11", "coincident close",
               int'({detect, done, busy}), 6);
         tick_n(1);
         check(done === 1'b0, "R11", "single done", int'(done), 0);
      end

      // R12: configuration changed mid-window
      cur_req = "R12";
      defaults(); go();
      cfg_need = 8'd1; cfg_thr = 24'd10; cfg_len = 16'd2; cfg_all = 1'b1;
      smp(90000, 0, 0); smp(50, 50, 50); smp(50, 50, 50);
      check(detect === 1'b0 && busy === 1'b1, "R12", "latched config", int'({detect, busy}), 1);
      run_out();

      tick_n(2);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R7 watchdog actual=hang expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule